// File: doc/BRIEF.md
# Bus-Mapped Seconds Real-Time Clock

This block keeps wall time as a free-running 32-bit seconds count plus a 0..999 millisecond count. Both are advanced by a slow 32.768 kHz tick, which arrives as a one-cycle enable in the bus clock domain. A fractional accumulator turns the tick into milliseconds: each tick adds 1000 to the accumulator, and a millisecond is counted each time the total reaches 32768. A millisecond therefore lasts 32 or 33 ticks, and exactly 1000 milliseconds make up each 32768 ticks.

Software does not see the live counters. It sees copies, which are refreshed once every eight slow ticks. During the tick period just before each refresh, the block reports itself busy, and a seconds write issued in that window is dropped and flagged. Reading the millisecond register latches the visible seconds into a shadow register, so a following shadow read returns the seconds that match the milliseconds just read. A seconds alarm raises a write-one-to-clear status bit. An active-high level interrupt is driven from the status bits that are enabled by a mask.

Top module: `bus_rtc`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: After T slow ticks from reset, the total millisecond count is floor(T*1000/32768). The millisecond field wraps from 999 to 0, and seconds increment at that wrap.
- R3: Bit 0 of the busy register (offset 0x04) reads 1 exactly while the number of ticks since reset modulo 8 equals 7. Otherwise it reads 0.
- R4: The seconds (0x08) and milliseconds (0x10) registers are refreshed only on the tick that ends a busy period. They then show the counts that include that tick, so after any multiple of 8 ticks they match R2.
- R5: A read of the milliseconds register copies the visible seconds into the shadow register (0x0C). The shadow register changes at no other time.
- R6: A seconds write while busy is low loads the counter and the visible seconds at once. A seconds write while busy is high has no effect and sets sticky bit 1 of the busy register. Writing 1 to that bit clears it.
- R7: Status bit 0 sets on the tick where seconds advance to a value equal to a nonzero alarm 0 register (0x14). An alarm value of 0 never sets it, even when seconds wrap to 0.
- R8: The status register (0x2C) holds five bits: bit 0 seconds alarm 0, bit 1 seconds alarm 1, bit 2 millisecond alarm, bit 3 seconds countdown, bit 4 millisecond countdown. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when some status bit is set and the mask register (0x28) has the same bit set.
- R10: Alarm 1 (0x18) and the millisecond alarm (0x1C) read back what was written. The mask keeps only bits 4:0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse per 32.768 kHz period |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (needed for the shadow capture) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Active-high level interrupt |

## Verification
The bench walks the tick count across points where the millisecond rounding matters: 32 versus 33 ticks, 999 wrapping to 0, and the rollover to a new second. A design that copied the counts before the tick had been applied would show values one millisecond behind. A design with a wrong accumulator would drift by whole milliseconds. It issues a seconds write inside the busy window and checks that the write is dropped and the error bit is set; a design that ignored busy would show the new seconds value. It also confirms that the shadow register stays frozen when seconds are rewritten. It steers seconds onto a nonzero alarm and then across a 0xFFFFFFFF-to-0 wrap with the alarm set to 0. A design that compared against a zero alarm would raise a spurious interrupt.

// File: rtl/bus_rtc.sv
module bus_rtc #(
  parameter int ADDR_W        = 8,
  parameter int SEC_W         = 32,
  parameter int TICKS_PER_SEC = 32768,
  parameter int MS_PER_SEC    = 1000,
  parameter int COPY_PERIOD   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int MS_W  = $clog2(MS_PER_SEC);
  localparam int ACC_W = $clog2(TICKS_PER_SEC) + 1;
  localparam int PH_W  = $clog2(COPY_PERIOD);
  localparam logic [ADDR_W-1:0] OFS_BUSY = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_SEC  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_SHD  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_MS   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_AL0  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFS_AL1  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_MSAL = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] OFS_MSK  = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] OFS_STS  = ADDR_W'('h2C);

  logic [ACC_W-1:0] acc, acc_sum;
  logic [MS_W-1:0]  ms_cnt, ms_nxt, bus_ms, msalm;
  logic [SEC_W-1:0] sec_cnt, sec_nxt, sec_inc, bus_sec, shadow, alm0, alm1;
  logic [PH_W-1:0]  phase;
  logic [4:0]       msk, sts, sts_clr;
  logic             err, busy, copy, ms_step, ms_wrap, sec_wr, sec_wr_ok, alarm_hit;

  assign acc_sum   = acc + ACC_W'(MS_PER_SEC);
  assign ms_step   = slow_tick && (acc_sum >= ACC_W'(TICKS_PER_SEC));
  assign ms_wrap   = ms_step && (ms_cnt == MS_W'(MS_PER_SEC - 1));
  assign ms_nxt    = ms_wrap ? '0 : (ms_step ? ms_cnt + 1'b1 : ms_cnt);
  assign busy      = (phase == PH_W'(COPY_PERIOD - 1));
  assign copy      = slow_tick && busy;
  assign sec_wr    = wr_en && (addr == OFS_SEC);
  assign sec_wr_ok = sec_wr && !busy;
  assign sec_inc   = sec_cnt + 1'b1;
  assign sec_nxt   = sec_wr_ok ? wdata[SEC_W-1:0] : (ms_wrap ? sec_inc : sec_cnt);
  assign alarm_hit = ms_wrap && !sec_wr_ok && (alm0 != '0) && (sec_inc == alm0);
  assign sts_clr   = (wr_en && addr == OFS_STS) ? wdata[4:0] : 5'd0;
  assign irq       = |(sts & msk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; ms_cnt <= '0; sec_cnt <= '0; phase <= '0;
      bus_sec <= '0; bus_ms <= '0; shadow <= '0;
      alm0 <= '0; alm1 <= '0; msalm <= '0;
      msk <= '0; sts <= '0; err <= 1'b0;
    end else begin
      if (slow_tick) begin
        acc   <= ms_step ? acc_sum - ACC_W'(TICKS_PER_SEC) : acc_sum;
        phase <= phase + 1'b1;
      end
      ms_cnt  <= ms_nxt;
      sec_cnt <= sec_nxt;
      if (sec_wr_ok)   bus_sec <= wdata[SEC_W-1:0];
      else if (copy)   bus_sec <= sec_nxt;
      if (copy)        bus_ms  <= ms_nxt;
      if (rd_en && addr == OFS_MS) shadow <= bus_sec;
      if (sec_wr && busy) err <= 1'b1;
      else if (wr_en && addr == OFS_BUSY && wdata[1]) err <= 1'b0;
      if (wr_en && addr == OFS_AL0)  alm0  <= wdata[SEC_W-1:0];
      if (wr_en && addr == OFS_AL1)  alm1  <= wdata[SEC_W-1:0];
      if (wr_en && addr == OFS_MSAL) msalm <= wdata[MS_W-1:0];
      if (wr_en && addr == OFS_MSK)  msk   <= wdata[4:0];
      sts <= (sts & ~sts_clr) | {4'd0, alarm_hit};
    end
  end

  always_comb begin
    case (addr)
      OFS_BUSY: rdata = {30'd0, err, busy};
      OFS_SEC:  rdata = 32'(bus_sec);
      OFS_SHD:  rdata = 32'(shadow);
      OFS_MS:   rdata = 32'(bus_ms);
      OFS_AL0:  rdata = 32'(alm0);
      OFS_AL1:  rdata = 32'(alm1);
      OFS_MSAL: rdata = 32'(msalm);
      OFS_MSK:  rdata = {27'd0, msk};
      OFS_STS:  rdata = {27'd0, sts};
      default:  rdata = 32'd0;
    endcase
  end
endmodule

module bus_rtc_chk #(
  parameter int ADDR_W = 8,
  parameter int SEC_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slow_tick,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic              busy,
  input logic              err,
  input logic [SEC_W-1:0]  sec_cnt,
  input logic [SEC_W-1:0]  bus_sec,
  input logic [SEC_W-1:0]  shadow,
  input logic [SEC_W-1:0]  alm0,
  input logic [4:0]        sts
);
  localparam logic [ADDR_W-1:0] C_SEC = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] C_MS  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] C_STS = ADDR_W'('h2C);

  AST_BUSY_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n) busy && slow_tick |=> !busy); // R3
  AST_VISIBLE_SEC_HELD: assert property (@(posedge clk) disable iff (!rst_n) !(busy && slow_tick) && !(wr_en && addr == C_SEC) |=> $stable(bus_sec)); // R4
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n) !(rd_en && addr == C_MS) |=> $stable(shadow)); // R5
  AST_BUSY_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) wr_en && addr == C_SEC && busy |=> err); // R6
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) wr_en && addr == C_SEC && busy && !slow_tick |=> $stable(sec_cnt)); // R6
  AST_ZERO_ALARM_SILENT: assert property (@(posedge clk) disable iff (!rst_n) alm0 == '0 |=> !$rose(sts[0])); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && addr == C_STS) |=> (($past(sts) & ~sts) == 5'd0)); // R8
endmodule

bind bus_rtc bus_rtc_chk #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .addr(addr), .wr_en(wr_en),
  .rd_en(rd_en), .busy(busy), .err(err), .sec_cnt(sec_cnt), .bus_sec(bus_sec),
  .shadow(shadow), .alm0(alm0), .sts(sts)
);

// File: tb/bus_rtc_test.sv
module bus_rtc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  int t_now = 0;

  bus_rtc uut (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .addr(addr),
               .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #4 clk = ~clk;

  localparam int unsigned VT [8][3] = '{
    '{8, 0, 0}, '{40, 1, 0}, '{328, 10, 0}, '{3280, 100, 0},
    '{32768, 0, 1}, '{32776, 0, 1}, '{40960, 250, 1}, '{65544, 0, 2}};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    if (n > 0) begin
      @(negedge clk); slow_tick = 1'b1;
      repeat (n) @(negedge clk);
      slow_tick = 1'b0;
      t_now += n;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 'h30; a += 4) begin
      rd(8'(a), v); check("R1 reset register", v, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);

    wr(8'h18, 32'hDEAD_BEEF); rd(8'h18, v); check("R10 alarm1 readback", v, 32'hDEAD_BEEF);
    wr(8'h1C, 32'd517);       rd(8'h1C, v); check("R10 ms alarm readback", v, 32'd517);
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); check("R10 mask width", v, 32'h1F);
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, v); check("R8 clear of clear status", v, 32'd0);
    check("R9 no status no irq", {31'd0, irq}, 32'd0);
    wr(8'h28, 32'd0);
    wr(8'h20, 32'h1234_5678); rd(8'h20, v); check("R10 unmapped reads 0", v, 32'd0);

    for (int i = 0; i < 8; i++) begin
      tick(int'(VT[i][0]) - t_now);
      rd(8'h10, v); check("R2 R4 visible ms", v, VT[i][1]);
      rd(8'h08, v); check("R2 R4 visible sec", v, VT[i][2]);
      rd(8'h04, v); check("R3 idle after copy", v, 32'd0);
    end

    tick(7);
    rd(8'h04, v); check("R3 busy in window", v, 32'd1);
    wr(8'h08, 32'd100);
    rd(8'h08, v); check("R6 busy write dropped", v, 32'd2);
    rd(8'h04, v); check("R6 error flagged", v, 32'd3);
    tick(1);
    rd(8'h04, v); check("R3 R6 busy off error sticky", v, 32'd2);
    rd(8'h08, v); check("R6 counter not loaded", v, 32'd2);
    wr(8'h04, 32'd2);
    rd(8'h04, v); check("R6 error cleared", v, 32'd0);

    wr(8'h08, 32'd5);
    rd(8'h08, v); check("R6 idle write loads", v, 32'd5);
    rd(8'h10, v); check("R5 ms read value", v, 32'd0);
    rd(8'h0C, v); check("R5 shadow captured", v, 32'd5);
    wr(8'h08, 32'd7);
    rd(8'h0C, v); check("R5 shadow frozen", v, 32'd5);

    wr(8'h14, 32'd8); rd(8'h14, v); check("R10 alarm0 readback", v, 32'd8);
    wr(8'h28, 32'd1);
    tick(98296 - t_now);
    rd(8'h10, v); check("R2 ms at 999", v, 32'd999);
    rd(8'h08, v); check("R2 sec before wrap", v, 32'd7);
    rd(8'h2C, v); check("R7 no early alarm", v, 32'd0);
    check("R9 irq low early", {31'd0, irq}, 32'd0);
    tick(8);
    rd(8'h08, v); check("R2 sec after wrap", v, 32'd8);
    rd(8'h10, v); check("R2 ms wrap to 0", v, 32'd0);
    rd(8'h2C, v); check("R7 alarm status set", v, 32'd1);
    check("R9 irq high", {31'd0, irq}, 32'd1);

    wr(8'h2C, 32'd0); rd(8'h2C, v); check("R8 write 0 keeps", v, 32'd1);
    wr(8'h28, 32'd0); check("R9 masked irq low", {31'd0, irq}, 32'd0);
    wr(8'h28, 32'd1); check("R9 unmasked irq high", {31'd0, irq}, 32'd1);
    wr(8'h2C, 32'd1); rd(8'h2C, v); check("R8 write 1 clears", v, 32'd0);
    check("R9 irq after clear", {31'd0, irq}, 32'd0);

    wr(8'h14, 32'd0);
    wr(8'h08, 32'hFFFF_FFFF);
    tick(131072 - t_now);
    rd(8'h08, v); check("R2 seconds wrap", v, 32'd0);
    rd(8'h2C, v); check("R7 zero alarm silent", v, 32'd0);
    check("R7 R9 irq stays low", {31'd0, irq}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule